// File: doc/BRIEF.md
# Recovering Store Forwarder

This block helps the core recover from loads whose faults were deferred. Each load that faulted without trapping left behind a slot. The slot holds the effective address it tried to read, the index of the register it should have filled and a flag that names the register file (integer or floating-point). When a store executes, the block compares the store address with every active slot, in ascending index order. On the first match it requests invalidation, with flush, of the cache line that holds the address. It then writes the stored data, masked to the access size, into the register named by the slot. This completes the faulted load after the fact.

The store request carries the address, the first source register index, a size code and the source register file. The slots are read in parallel through flat vectors, together with a count of how many slots are configured. The source data comes from a combinational register read port driven by the block. Register writes leave through a valid/ready port, one word per cycle. A store of more than four bytes is spread over consecutive source and destination registers. The cache and both register files lie outside the block.

Top module: `recov_store_fwd`

## Requirements
- R1: While `rst_n` is low and after its release, `busy`, `wr_valid` and `inv_valid` are low until a store is accepted.
- R2: A store is accepted on a rising edge where `st_valid` is high and `busy` is low. A slot takes part in the comparison only if its valid bit is set and its index is below `slot_count`. If no such slot has an address equal to `st_addr`, no invalidate and no register write are issued, `busy` stays low and the next store can be accepted on the following edge.
- R3: When several participating slots match, only the one with the lowest index is used.
- R4: On a match, `inv_valid` is high for exactly the one cycle after the accepting edge. During that cycle `inv_addr` equals `st_addr` with its low log2(`LINE_BYTES`) bits cleared.
- R5: The size code `st_size` masks the data: 0 (byte) writes `src_rd_data & 0xFF`, 1 (halfword) writes `src_rd_data & 0xFFFF`, and 2 (word), 3 and 4 write the data unmasked. Codes 5 to 7 behave as a word.
- R6: Size code 3 (eight bytes) issues two register writes and code 4 (sixteen bytes) issues four. Codes 0 to 2 issue one. Write k (from 0) goes to register `dst + k`, where `dst` is the matched slot's register index, and carries data read from source register `st_src_idx + k`. Writes are issued in ascending k.
- R7: `wr_fp` equals the register-file flag of the matched slot. The store's own `st_fp` only selects the source file, presented on `src_rd_fp`.
- R8: A write is transferred on each edge where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low, `wr_valid`, `wr_idx` and `wr_fp` hold. `busy` is high from the cycle after the accepting edge until the edge that transfers the last write. `wr_valid` is never high without `busy`.
- R9: A `st_valid` pulse while `busy` is high is ignored: it produces no invalidate and no additional write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request present |
| st_addr | input | ADDR_W | Store byte address |
| st_src_idx | input | RIDX_W | First source register index |
| st_size | input | 3 | Size code (0 byte, 1 half, 2 word, 3 eight bytes, 4 sixteen bytes) |
| st_fp | input | 1 | Source register file is floating-point |
| slot_count | input | CNT_W | Number of configured slots |
| slot_valid | input | NSLOTS | Per-slot valid bit |
| slot_addr | input | NSLOTS*ADDR_W | Per-slot recorded address, slot i at bits [i*ADDR_W +: ADDR_W] |
| slot_dst | input | NSLOTS*RIDX_W | Per-slot destination register index |
| slot_fp | input | NSLOTS | Per-slot destination file flag |
| src_rd_idx | output | RIDX_W | Source register read index |
| src_rd_fp | output | 1 | Source register read file select |
| src_rd_data | input | 32 | Source register read data (combinational) |
| wr_valid | output | 1 | Register write request |
| wr_ready | input | 1 | Register write accepted |
| wr_idx | output | RIDX_W | Destination register index |
| wr_fp | output | 1 | Destination file is floating-point |
| wr_data | output | 32 | Write data, masked by size |
| inv_valid | output | 1 | Cache line invalidate-with-flush request |
| inv_addr | output | ADDR_W | Line-aligned address to invalidate |
| busy | output | 1 | Forwarding in progress |

## Verification
Every result of an accepted store appears one register stage after the accepting edge. The invalidate pulse, the first write request and `busy` all show at the first falling edge after that rising edge. Each later write appears at the falling edge after the rising edge that transferred the previous one. `busy` drops at the falling edge after the final transfer. The bench drives each request at a falling edge and samples at exactly these falling edges. Where it withholds `wr_ready`, it samples twice more to confirm the request holds and the invalidate does not repeat. A miss is judged at the first falling edge after acceptance, where all three outputs must still be low.

// File: rtl/rsf_pkg.sv
package rsf_pkg;

  localparam int WORD_W    = 32;
  localparam int MAX_WORDS = 4;
  localparam int STEP_W    = $clog2(MAX_WORDS);

  typedef enum logic [2:0] {
    SZ_BYTE = 3'd0,
    SZ_HALF = 3'd1,
    SZ_WORD = 3'd2,
    SZ_DUAL = 3'd3,
    SZ_QUAD = 3'd4
  } size_code_e;

  typedef enum logic {
    FWD_IDLE  = 1'b0,
    FWD_WRITE = 1'b1
  } fwd_state_e;

  // Index of the last word of a store of the given size
  function automatic logic [STEP_W-1:0] last_step(input logic [2:0] sz);
    logic [STEP_W-1:0] r;
    case (sz)
      SZ_DUAL: r = STEP_W'(1);
      SZ_QUAD: r = STEP_W'(3);
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rsf_slot_match.sv
module rsf_slot_match #(
  parameter int ADDR_W = 32,
  parameter int NSLOTS = 4,
  parameter int CNT_W  = $clog2(NSLOTS + 1),
  parameter int IDX_W  = (NSLOTS > 1) ? $clog2(NSLOTS) : 1
) (
  input  logic [ADDR_W-1:0]        st_addr,
  input  logic [CNT_W-1:0]         slot_count,
  input  logic [NSLOTS-1:0]        slot_valid,
  input  logic [NSLOTS*ADDR_W-1:0] slot_addr,
  output logic                     hit,
  output logic [IDX_W-1:0]         hit_idx
);

  logic [NSLOTS-1:0] cand;

  // Per-slot compare: enabled, configured and equal
  for (genvar g = 0; g < NSLOTS; g++) begin : g_cmp
    localparam logic [CNT_W-1:0] SLOT_NUM = CNT_W'(g);
    logic in_range;
    logic addr_eq;
    assign in_range = (SLOT_NUM < slot_count);
    assign addr_eq  = (slot_addr[g*ADDR_W +: ADDR_W] == st_addr);
    assign cand[g]  = slot_valid[g] & in_range & addr_eq;
  end

  // Lowest index wins: scan downward so the last assignment is the lowest
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = NSLOTS - 1; i >= 0; i--) begin
      if (cand[i]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/rsf_word_shaper.sv
module rsf_word_shaper
  import rsf_pkg::*;
(
  input  logic [2:0]        size,
  input  logic [WORD_W-1:0] raw,
  output logic [WORD_W-1:0] shaped
);

  logic [WORD_W-1:0] keep;

  always_comb begin
    case (size)
      SZ_BYTE: keep = WORD_W'(32'h0000_00FF);
      SZ_HALF: keep = WORD_W'(32'h0000_FFFF);
      default: keep = '1;
    endcase
    shaped = raw & keep;
  end

endmodule

// File: rtl/rsf_write_seq.sv
module rsf_write_seq
  import rsf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int RIDX_W     = 6,
  parameter int LINE_BYTES = 32,
  localparam int OFF_W     = $clog2(LINE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  input  logic              hit,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [RIDX_W-1:0] st_src_idx,
  input  logic [2:0]        st_size,
  input  logic              st_fp,
  input  logic [RIDX_W-1:0] sel_dst,
  input  logic              sel_fp,
  input  logic              wr_ready,
  output logic              busy,
  output logic              wr_valid,
  output logic [RIDX_W-1:0] wr_idx,
  output logic              wr_fp,
  output logic [RIDX_W-1:0] src_rd_idx,
  output logic              src_rd_fp,
  output logic [2:0]        cur_size,
  output logic              inv_valid,
  output logic [ADDR_W-1:0] inv_addr
);

  fwd_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              inv_q, inv_d;
  logic              load_en;

  logic [STEP_W-1:0] last_q;
  logic [RIDX_W-1:0] dst_q;
  logic              dfp_q;
  logic [RIDX_W-1:0] src_q;
  logic              sfp_q;
  logic [2:0]        size_q;
  logic [ADDR_W-1:0] line_q;
  logic [ADDR_W-1:0] line_d;

  assign line_d = {st_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  // Next state
  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    inv_d   = 1'b0;
    load_en = 1'b0;
    case (state_q)
      FWD_IDLE: begin
        if (st_valid && hit) begin
          state_d = FWD_WRITE;
          step_d  = '0;
          inv_d   = 1'b1;
          load_en = 1'b1;
        end
      end
      FWD_WRITE: begin
        if (wr_ready) begin
          if (step_q == last_q) begin
            state_d = FWD_IDLE;
          end else begin
            step_d = step_q + 1'b1;
          end
        end
      end
      default: state_d = FWD_IDLE;
    endcase
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FWD_IDLE;
      step_q  <= '0;
      inv_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      inv_q   <= inv_d;
    end
  end

  // Captured request, loaded only on a matching accept
  always_ff @(posedge clk) begin
    if (load_en) begin
      last_q <= last_step(st_size);
      dst_q  <= sel_dst;
      dfp_q  <= sel_fp;
      src_q  <= st_src_idx;
      sfp_q  <= st_fp;
      size_q <= st_size;
      line_q <= line_d;
    end
  end

  assign busy       = (state_q == FWD_WRITE);
  assign wr_valid   = busy;
  assign wr_idx     = dst_q + RIDX_W'(step_q);
  assign wr_fp      = dfp_q;
  assign src_rd_idx = src_q + RIDX_W'(step_q);
  assign src_rd_fp  = sfp_q;
  assign cur_size   = size_q;
  assign inv_valid  = inv_q;
  assign inv_addr   = line_q;

endmodule

// File: rtl/recov_store_fwd.sv
module recov_store_fwd
  import rsf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NSLOTS     = 4,
  parameter int RIDX_W     = 6,
  parameter int LINE_BYTES = 32,
  localparam int CNT_W     = $clog2(NSLOTS + 1),
  localparam int IDX_W     = (NSLOTS > 1) ? $clog2(NSLOTS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     st_valid,
  input  logic [ADDR_W-1:0]        st_addr,
  input  logic [RIDX_W-1:0]        st_src_idx,
  input  logic [2:0]               st_size,
  input  logic                     st_fp,
  input  logic [CNT_W-1:0]         slot_count,
  input  logic [NSLOTS-1:0]        slot_valid,
  input  logic [NSLOTS*ADDR_W-1:0] slot_addr,
  input  logic [NSLOTS*RIDX_W-1:0] slot_dst,
  input  logic [NSLOTS-1:0]        slot_fp,
  output logic [RIDX_W-1:0]        src_rd_idx,
  output logic                     src_rd_fp,
  input  logic [WORD_W-1:0]        src_rd_data,
  output logic                     wr_valid,
  input  logic                     wr_ready,
  output logic [RIDX_W-1:0]        wr_idx,
  output logic                     wr_fp,
  output logic [WORD_W-1:0]        wr_data,
  output logic                     inv_valid,
  output logic [ADDR_W-1:0]        inv_addr,
  output logic                     busy
);

  logic              hit;
  logic [IDX_W-1:0]  hit_idx;
  logic [RIDX_W-1:0] sel_dst;
  logic              sel_fp;
  logic [2:0]        cur_size;

  rsf_slot_match #(
    .ADDR_W (ADDR_W),
    .NSLOTS (NSLOTS),
    .CNT_W  (CNT_W),
    .IDX_W  (IDX_W)
  ) u_match (
    .st_addr    (st_addr),
    .slot_count (slot_count),
    .slot_valid (slot_valid),
    .slot_addr  (slot_addr),
    .hit        (hit),
    .hit_idx    (hit_idx)
  );

  assign sel_dst = slot_dst[hit_idx*RIDX_W +: RIDX_W];
  assign sel_fp  = slot_fp[hit_idx];

  rsf_write_seq #(
    .ADDR_W     (ADDR_W),
    .RIDX_W     (RIDX_W),
    .LINE_BYTES (LINE_BYTES)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .st_valid   (st_valid),
    .hit        (hit),
    .st_addr    (st_addr),
    .st_src_idx (st_src_idx),
    .st_size    (st_size),
    .st_fp      (st_fp),
    .sel_dst    (sel_dst),
    .sel_fp     (sel_fp),
    .wr_ready   (wr_ready),
    .busy       (busy),
    .wr_valid   (wr_valid),
    .wr_idx     (wr_idx),
    .wr_fp      (wr_fp),
    .src_rd_idx (src_rd_idx),
    .src_rd_fp  (src_rd_fp),
    .cur_size   (cur_size),
    .inv_valid  (inv_valid),
    .inv_addr   (inv_addr)
  );

  rsf_word_shaper u_shape (
    .size   (cur_size),
    .raw    (src_rd_data),
    .shaped (wr_data)
  );

endmodule

// File: rtl/rsf_checker.sv
module rsf_checker #(
  parameter int RIDX_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [RIDX_W-1:0] wr_idx,
  input logic              wr_fp,
  input logic [31:0]       wr_data,
  input logic [2:0]        cur_size,
  input logic              inv_valid
);

  // R4
  inv_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |=> !inv_valid);

  // R4
  inv_with_first_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> (wr_valid && busy));

  // R8
  write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_idx) && $stable(wr_fp)));

  // R6
  dest_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (wr_valid |-> (wr_idx == RIDX_W'($past(wr_idx) + 1'b1))));

  // R5
  byte_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && cur_size == 3'd0) |-> (wr_data[31:8] == 24'd0));

  // R5
  half_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && cur_size == 3'd1) |-> (wr_data[31:16] == 16'd0));

  // R8
  write_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> busy);

endmodule

bind recov_store_fwd rsf_checker #(.RIDX_W(RIDX_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_idx    (wr_idx),
  .wr_fp     (wr_fp),
  .wr_data   (wr_data),
  .cur_size  (cur_size),
  .inv_valid (inv_valid)
);

// File: tb/recov_store_fwd_tb_top.sv
module recov_store_fwd_tb_top;

  localparam int AW = 32;
  localparam int NS = 4;
  localparam int RW = 6;
  localparam int CW = 3;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           st_valid;
  logic [AW-1:0]  st_addr;
  logic [RW-1:0]  st_src_idx;
  logic [2:0]     st_size;
  logic           st_fp;
  logic [CW-1:0]  slot_count;
  logic [NS-1:0]  slot_valid;
  logic [NS*AW-1:0] slot_addr;
  logic [NS*RW-1:0] slot_dst;
  logic [NS-1:0]  slot_fp;
  logic [RW-1:0]  src_rd_idx;
  logic           src_rd_fp;
  logic [31:0]    src_rd_data;
  logic           wr_valid;
  logic           wr_ready;
  logic [RW-1:0]  wr_idx;
  logic           wr_fp;
  logic [31:0]    wr_data;
  logic           inv_valid;
  logic [AW-1:0]  inv_addr;
  logic           busy;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  recov_store_fwd dut_i (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
    .st_src_idx(st_src_idx), .st_size(st_size), .st_fp(st_fp),
    .slot_count(slot_count), .slot_valid(slot_valid), .slot_addr(slot_addr),
    .slot_dst(slot_dst), .slot_fp(slot_fp), .src_rd_idx(src_rd_idx),
    .src_rd_fp(src_rd_fp), .src_rd_data(src_rd_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_idx(wr_idx), .wr_fp(wr_fp), .wr_data(wr_data),
    .inv_valid(inv_valid), .inv_addr(inv_addr), .busy(busy)
  );

  // Register file model for the source read port
  function automatic logic [31:0] reg_model(input logic [RW-1:0] idx, input logic fp);
    logic [31:0] v;
    v = 32'h1357_9BDF * (32'(idx) + 32'd1);
    if (fp) v = v ^ 32'hF0F0_0F0F;
    return v | 32'h8080_8000;
  endfunction

  always_comb src_rd_data = reg_model(src_rd_idx, src_rd_fp);

  function automatic logic [31:0] exp_mask(input logic [2:0] sz, input logic [31:0] v);
    if (sz == 3'd0) return v & 32'hFF;
    if (sz == 3'd1) return v & 32'hFFFF;
    return v;
  endfunction

  function automatic int words_of(input logic [2:0] sz);
    if (sz == 3'd3) return 2;
    if (sz == 3'd4) return 4;
    return 1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_slot(input int i, input logic v, input logic [AW-1:0] a,
                          input logic [RW-1:0] d, input logic fp);
    slot_valid[i]        = v;
    slot_addr[i*AW +: AW] = a;
    slot_dst[i*RW +: RW] = d;
    slot_fp[i]           = fp;
  endtask

  // Issue one store at a falling edge and check the full result sequence
  task automatic run_store(input logic [AW-1:0] a, input logic [2:0] sz, input logic [RW-1:0] src,
                           input logic sfp, input bit stall, input bit hit,
                           input logic [RW-1:0] dst, input logic dfp, input string tag);
    st_valid = 1'b1; st_addr = a; st_size = sz; st_src_idx = src; st_fp = sfp;
    wr_ready = 1'b0;
    @(negedge clk);
    st_valid = 1'b0;
    if (!hit) begin
      // R2 miss: nothing issued, not busy
      chk(!inv_valid && !wr_valid && !busy, {tag, " R2 miss"},
          {inv_valid, wr_valid, busy}, 3'b000);
      return;
    end
    // R4 invalidate pulse with line-aligned address
    chk(inv_valid, {tag, " R4 inv pulse"}, inv_valid, 1);
    chk(inv_addr == {a[AW-1:5], 5'd0}, {tag, " R4 inv addr"}, inv_addr, {a[AW-1:5], 5'd0});
    for (int k = 0; k < words_of(sz); k++) begin
      if (stall) begin
        wr_ready = 1'b0;
        @(negedge clk);
        // R8 request held while not ready
        chk(wr_valid && wr_idx == RW'(dst + k), {tag, " R8 hold"}, wr_idx, RW'(dst + k));
        chk(!inv_valid, {tag, " R4 no repeat"}, inv_valid, 0);
      end
      wr_ready = 1'b1;
      // R6 R7 R5 per-word values
      chk(wr_valid && busy, {tag, " R8 valid"}, {wr_valid, busy}, 2'b11);
      chk(wr_idx == RW'(dst + k), {tag, " R6 dst idx"}, wr_idx, RW'(dst + k));
      chk(wr_fp == dfp, {tag, " R7 dst file"}, wr_fp, dfp);
      chk(wr_data == exp_mask(sz, reg_model(RW'(src + k), sfp)), {tag, " R5 R6 data"},
          wr_data, exp_mask(sz, reg_model(RW'(src + k), sfp)));
      @(negedge clk);
    end
    wr_ready = 1'b0;
    chk(!busy && !wr_valid && !inv_valid, {tag, " R8 done"}, {busy, wr_valid, inv_valid}, 3'b000);
  endtask

  typedef struct packed {
    logic [31:0] addr;
    logic [2:0]  sz;
    logic [5:0]  src;
    logic        sfp;
    logic        stall;
    logic        hit;
    logic [5:0]  dst;
    logic        dfp;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{32'h0001_0104, 3'd0, 6'd3,  1'b0, 1'b0, 1'b1, 6'd10, 1'b0},
    '{32'h0001_0104, 3'd1, 6'd5,  1'b1, 1'b1, 1'b1, 6'd10, 1'b0},
    '{32'h0002_0208, 3'd2, 6'd7,  1'b0, 1'b0, 1'b1, 6'd20, 1'b1},
    '{32'h0002_0208, 3'd3, 6'd12, 1'b0, 1'b1, 1'b1, 6'd20, 1'b1},
    '{32'h0003_0300, 3'd4, 6'd16, 1'b1, 1'b0, 1'b1, 6'd40, 1'b0},
    '{32'h0004_0000, 3'd2, 6'd1,  1'b0, 1'b0, 1'b0, 6'd0,  1'b0},
    '{32'h0001_0100, 3'd2, 6'd1,  1'b0, 1'b0, 1'b0, 6'd0,  1'b0},
    '{32'h0002_0208, 3'd4, 6'd60, 1'b1, 1'b1, 1'b1, 6'd20, 1'b1}
  };

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog expired R8 actual=hung expected=done");
    failures++;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; st_valid = 1'b0; st_addr = '0; st_src_idx = '0; st_size = '0;
    st_fp = 1'b0; wr_ready = 1'b0; slot_count = CW'(4);
    slot_valid = '0; slot_addr = '0; slot_dst = '0; slot_fp = '0;
    set_slot(0, 1'b1, 32'h0001_0104, 6'd10, 1'b0);
    set_slot(1, 1'b1, 32'h0002_0208, 6'd20, 1'b1);
    set_slot(2, 1'b0, 32'h0003_0300, 6'd30, 1'b0);
    set_slot(3, 1'b1, 32'h0003_0300, 6'd40, 1'b0);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !wr_valid && !inv_valid, "R1 in reset", {busy, wr_valid, inv_valid}, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !wr_valid && !inv_valid, "R1 after release", {busy, wr_valid, inv_valid}, 3'b000);

    for (int v = 0; v < NV; v++) begin
      run_store(VECS[v].addr, VECS[v].sz, VECS[v].src, VECS[v].sfp, VECS[v].stall,
                VECS[v].hit, VECS[v].dst, VECS[v].dfp, $sformatf("vec%0d", v));
    end

    // R3: duplicate address, lowest slot wins
    set_slot(3, 1'b1, 32'h0001_0104, 6'd40, 1'b1);
    run_store(32'h0001_0104, 3'd2, 6'd9, 1'b0, 1'b0, 1'b1, 6'd10, 1'b0, "dup R3");
    set_slot(3, 1'b1, 32'h0003_0300, 6'd40, 1'b0);

    // R2: slot beyond configured count ignored
    slot_count = CW'(3);
    run_store(32'h0003_0300, 3'd2, 6'd9, 1'b0, 1'b0, 1'b0, 6'd0, 1'b0, "count R2");
    slot_count = CW'(4);

    // R2: back-to-back after a miss, accepted on the next edge
    run_store(32'h0003_0300, 3'd2, 6'd2, 1'b0, 1'b0, 1'b1, 6'd40, 1'b0, "after miss R2");

    // R9: store during busy ignored
    st_valid = 1'b1; st_addr = 32'h0001_0104; st_size = 3'd2; st_src_idx = 6'd4; st_fp = 1'b0;
    wr_ready = 1'b0;
    @(negedge clk);
    st_addr = 32'h0002_0208; st_size = 3'd4;
    chk(busy && inv_valid, "R9 first accepted", {busy, inv_valid}, 2'b11);
    @(negedge clk);
    st_valid = 1'b0;
    chk(!inv_valid && wr_idx == 6'd10, "R9 no new invalidate", {inv_valid, wr_idx}, {1'b0, 6'd10});
    wr_ready = 1'b1;
    @(negedge clk);
    wr_ready = 1'b0;
    for (int c = 0; c < 3; c++) begin
      chk(!busy && !wr_valid && !inv_valid, "R9 ignored store", {busy, wr_valid, inv_valid}, 3'b000);
      @(negedge clk);
    end

    // R1: reset in the middle of a multi-word write
    st_valid = 1'b1; st_addr = 32'h0002_0208; st_size = 3'd4; st_src_idx = 6'd0; st_fp = 1'b0;
    @(negedge clk);
    st_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk(!busy && !wr_valid && !inv_valid, "R1 async reset", {busy, wr_valid, inv_valid}, 3'b000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !wr_valid, "R1 idle after reset", {busy, wr_valid}, 2'b00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule